// File: doc/BRIEF.md
# Banked Nibble Data Memory

This block is the data store of a small 4-bit controller. Every location holds one nibble. A 7-bit address selects the location: its upper three bits give the row and its lower four bits give the column, so row 2 with column 5 is location 25h. There are two banks, and a bank select input picks one of them. Several special regions sit on the same address space. Locations 74h through 7Fh form a control window that both banks share. Bank 0 holds a four-nibble buffer at 0Ch through 0Fh, which comes out of reset with a preset value. Bank 0 also holds five port data nibbles, at 6Fh and at 70h through 73h. In bank 1, the locations 70h through 73h cannot be written, and reads there return the bank 0 contents.

There are two access paths. The main port has a synchronous write and a combinational read. The second port reaches a whole movable row, the working row. Its row number is the low three bits of the control nibble at 7Dh, and it accesses the column given by the port, in the bank currently selected. Setting the parameter `HAS_BANK1` to 0 removes bank 1 for the smaller variants.

Top module: `bnk_nibram`

## Requirements
- R1: After reset, every location reads 0, except bank 0 location 0Dh, which reads 3, and bank 0 location 0Eh, which reads 2. Locations 0Ch and 0Fh read 0.
- R2: A main-port write stores `wdata` at address (row*16 + col) of the selected bank. From the clock edge of the write onward, a read of that address returns the new value.
- R3: Outside the shared window and the bank 1 port area (addresses 00h–6Fh), the two banks are independent storage. A write to one bank leaves the same address in the other bank unchanged.
- R4: Addresses 74h–7Fh reach one shared set of 12 nibbles, whichever bank is selected.
- R5: A write with bank 1 selected to 70h–73h changes nothing. This holds for both the main port and the working-row port.
- R6: A read with bank 1 selected at 70h–73h returns the bank 0 value at that address.
- R7: `gr_rdata` combinationally returns the nibble at address {P[2:0], `gr_col`} in the selected bank, where P is the nibble at 7Dh. All the address rules of R4 and R6 apply to this address.
- R8: When `gr_wr_en` is high, `gr_wdata` is written at address {P[2:0], `gr_col`} at the clock edge, under the same rules as a main-port write, including R5.
- R9: When both ports write the same location in the same cycle, the main-port value is the one stored.
- R10: With `HAS_BANK1` = 0, `bank_sel` has no effect, and every access uses bank 0.
- R11: Reads have no latency. `rdata` follows `addr` and `bank_sel` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 1 | 0 selects bank 0, 1 selects bank 1 (both ports) |
| addr | input | 7 | Main-port address, row in [6:4], column in [3:0] |
| wr_en | input | 1 | Main-port write strobe |
| wdata | input | 4 | Main-port write nibble |
| rdata | output | 4 | Main-port read nibble |
| gr_col | input | 4 | Column within the working row |
| gr_wr_en | input | 1 | Working-row write strobe |
| gr_wdata | input | 4 | Working-row write nibble |
| gr_rdata | output | 4 | Working-row read nibble |

## Verification
The bench drives writes into bank 1 at 70h–73h. A design that leaked them would corrupt the bank 0 port nibbles. A design that stored them in bank 1 would return its own copy instead of the bank 0 alias.

It writes the shared window from one bank and reads it back from the other. Separate per-bank copies would show stale data there.

It moves the pointer at 7Dh with random writes and then reads the working row through the second port. A wrong row derivation shows up at once. It also aims the working row at row 7, where the shared window and the protected area meet.

It makes both ports write one cell in the same cycle, to catch a wrong priority. It also checks a variant built without bank 1, to catch a bank select that still steers accesses.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
    localparam int NIB_W     = 4;
    localparam int ROW_W     = 3;
    localparam int COL_W     = 4;
    localparam int ADDR_W    = ROW_W + COL_W;
    localparam int CELLS     = 1 << ADDR_W;
    localparam int SYS_BASE  = 'h74;
    localparam int SYS_CELLS = CELLS - SYS_BASE;
    localparam int SYS_IW    = $clog2(SYS_CELLS);
    localparam int PORT_LO   = 'h70;
    localparam int PORT_HI   = 'h73;
    localparam int PTR_ADDR  = 'h7D;
    localparam int PTR_OFF   = PTR_ADDR - SYS_BASE;
    localparam int DBUF_BASE = 'h0C;
    localparam int DBUF_LEN  = 4;
    localparam logic [DBUF_LEN*NIB_W-1:0] DBUF_RST = 16'h0320;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [COL_W-1:0]  col_t;

    typedef enum logic [1:0] {TGT_B0, TGT_B1, TGT_SYS} tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        addr_t idx;
        logic  wr_ok;
    } route_t;

    // Bank 0 reset image: buffer value laid out most significant nibble first.
    function automatic logic [CELLS*NIB_W-1:0] bank0_image();
        logic [CELLS*NIB_W-1:0] img;
        img = '0;
        for (int k = 0; k < DBUF_LEN; k++) begin
            img[(DBUF_BASE+k)*NIB_W +: NIB_W] = DBUF_RST[(DBUF_LEN-1-k)*NIB_W +: NIB_W];
        end
        return img;
    endfunction
endpackage

// File: rtl/bnk_route.sv
module bnk_route
    import bnk_pkg::*;
#(
    parameter bit HAS_BANK1 = 1'b1
) (
    input  logic   bank_sel,
    input  addr_t  addr,
    output route_t route
);
    logic use_b1;
    logic in_sys;
    logic in_port;

    always_comb begin
        use_b1  = HAS_BANK1 ? bank_sel : 1'b0;
        in_sys  = addr >= addr_t'(SYS_BASE);
        in_port = (addr >= addr_t'(PORT_LO)) && (addr <= addr_t'(PORT_HI));

        route.tgt   = use_b1 ? TGT_B1 : TGT_B0;
        route.idx   = addr;
        route.wr_ok = 1'b1;
        if (in_sys) begin
            route.tgt = TGT_SYS;
            route.idx = addr - addr_t'(SYS_BASE);
        end else if (use_b1 && in_port) begin
            // protected in bank 1: reads alias bank 0, writes dropped
            route.tgt   = TGT_B0;
            route.wr_ok = 1'b0;
        end
    end
endmodule

// File: rtl/bnk_store.sv
module bnk_store
    import bnk_pkg::*;
#(
    parameter int DEPTH = CELLS,
    parameter int IDX_W = $clog2(DEPTH),
    parameter logic [DEPTH*NIB_W-1:0] INIT = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        a_we,
    input  logic [IDX_W-1:0]            a_idx,
    input  nib_t                        a_wd,
    output nib_t                        a_rd,
    input  logic                        b_we,
    input  logic [IDX_W-1:0]            b_idx,
    input  nib_t                        b_wd,
    output nib_t                        b_rd,
    output logic [DEPTH-1:0][NIB_W-1:0] img
);
    typedef struct packed {
        logic [DEPTH-1:0][NIB_W-1:0] mem;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        // port b first so that port a wins on a shared index
        if (b_we) st_d.mem[b_idx] = b_wd;
        if (a_we) st_d.mem[a_idx] = a_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_t'(INIT);
        else        st_q <= st_d;
    end

    assign a_rd = st_q.mem[a_idx];
    assign b_rd = st_q.mem[b_idx];
    assign img  = st_q.mem;
endmodule

// File: rtl/bnk_nibram.sv
module bnk_nibram
    import bnk_pkg::*;
#(
    parameter bit HAS_BANK1 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bank_sel,
    input  logic [6:0] addr,
    input  logic       wr_en,
    input  logic [3:0] wdata,
    output logic [3:0] rdata,
    input  logic [3:0] gr_col,
    input  logic       gr_wr_en,
    input  logic [3:0] gr_wdata,
    output logic [3:0] gr_rdata
);
    localparam logic [CELLS*NIB_W-1:0] B0_INIT = bank0_image();

    route_t rt_a;
    route_t rt_b;
    addr_t  gr_addr;
    nib_t   ptr;

    logic b0_a_we, b0_b_we, b1_a_we, b1_b_we, sys_a_we, sys_b_we;
    nib_t b0_a_rd, b0_b_rd, b1_a_rd, b1_b_rd, sys_a_rd, sys_b_rd;

    logic [CELLS-1:0][NIB_W-1:0]     b0_img;
    logic [SYS_CELLS-1:0][NIB_W-1:0] sys_img;

    assign ptr     = sys_img[PTR_OFF];
    assign gr_addr = {ptr[ROW_W-1:0], gr_col};

    bnk_route #(.HAS_BANK1(HAS_BANK1)) u_route_a (
        .bank_sel (bank_sel),
        .addr     (addr),
        .route    (rt_a)
    );

    bnk_route #(.HAS_BANK1(HAS_BANK1)) u_route_b (
        .bank_sel (bank_sel),
        .addr     (gr_addr),
        .route    (rt_b)
    );

    always_comb begin
        b0_a_we  = wr_en    && rt_a.wr_ok && (rt_a.tgt == TGT_B0);
        b1_a_we  = wr_en    && rt_a.wr_ok && (rt_a.tgt == TGT_B1);
        sys_a_we = wr_en    && (rt_a.tgt == TGT_SYS);
        b0_b_we  = gr_wr_en && rt_b.wr_ok && (rt_b.tgt == TGT_B0);
        b1_b_we  = gr_wr_en && rt_b.wr_ok && (rt_b.tgt == TGT_B1);
        sys_b_we = gr_wr_en && (rt_b.tgt == TGT_SYS);
    end

    bnk_store #(.DEPTH(CELLS), .INIT(B0_INIT)) u_bank0 (
        .clk   (clk),
        .rst_n (rst_n),
        .a_we  (b0_a_we),
        .a_idx (rt_a.idx),
        .a_wd  (wdata),
        .a_rd  (b0_a_rd),
        .b_we  (b0_b_we),
        .b_idx (rt_b.idx),
        .b_wd  (gr_wdata),
        .b_rd  (b0_b_rd),
        .img   (b0_img)
    );

    generate
        if (HAS_BANK1) begin : g_bank1
            logic [CELLS-1:0][NIB_W-1:0] b1_img;
            bnk_store #(.DEPTH(CELLS)) u_bank1 (
                .clk   (clk),
                .rst_n (rst_n),
                .a_we  (b1_a_we),
                .a_idx (rt_a.idx),
                .a_wd  (wdata),
                .a_rd  (b1_a_rd),
                .b_we  (b1_b_we),
                .b_idx (rt_b.idx),
                .b_wd  (gr_wdata),
                .b_rd  (b1_b_rd),
                .img   (b1_img)
            );
        end else begin : g_nobank1
            assign b1_a_rd = '0;
            assign b1_b_rd = '0;
        end
    endgenerate

    bnk_store #(.DEPTH(SYS_CELLS)) u_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .a_we  (sys_a_we),
        .a_idx (rt_a.idx[SYS_IW-1:0]),
        .a_wd  (wdata),
        .a_rd  (sys_a_rd),
        .b_we  (sys_b_we),
        .b_idx (rt_b.idx[SYS_IW-1:0]),
        .b_wd  (gr_wdata),
        .b_rd  (sys_b_rd),
        .img   (sys_img)
    );

    always_comb begin
        case (rt_a.tgt)
            TGT_SYS: rdata = sys_a_rd;
            TGT_B1:  rdata = b1_a_rd;
            default: rdata = b0_a_rd;
        endcase
        case (rt_b.tgt)
            TGT_SYS: gr_rdata = sys_b_rd;
            TGT_B1:  gr_rdata = b1_b_rd;
            default: gr_rdata = b0_b_rd;
        endcase
    end
endmodule

// File: rtl/bnk_nibram_chk.sv
module bnk_nibram_chk
    import bnk_pkg::*;
#(
    parameter bit HAS_BANK1 = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bank_sel,
    input logic [6:0]                  addr,
    input logic                        wr_en,
    input logic [3:0]                  wdata,
    input logic [3:0]                  rdata,
    input logic [3:0]                  gr_col,
    input logic [3:0]                  gr_rdata,
    input logic [CELLS-1:0][NIB_W-1:0]     b0_img,
    input logic [SYS_CELLS-1:0][NIB_W-1:0] sys_img
);
    logic [3:0] sys_off;
    logic       in_port;
    row_t       wrow;

    assign sys_off = addr[3:0] - 4'd4;
    assign in_port = (addr >= 7'h70) && (addr <= 7'h73);
    assign wrow    = sys_img[PTR_OFF][ROW_W-1:0];

    // R2
    b0_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_sel && addr < 7'h70) |=> (b0_img[$past(addr)] == $past(wdata)));

    // R4
    sys_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= 7'h74) |=> (sys_img[$past(sys_off)] == $past(wdata)));

    // R5
    b1_port_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_BANK1 && wr_en && bank_sel && in_port) |=> $stable(b0_img[PORT_HI:PORT_LO]));

    // R6
    b1_port_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_BANK1 && bank_sel && in_port) |-> (rdata == b0_img[addr]));

    // R7
    gr_row_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel && wrow != 3'd7) |-> (gr_rdata == b0_img[{wrow, gr_col}]));
endmodule

bind bnk_nibram bnk_nibram_chk #(.HAS_BANK1(HAS_BANK1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (bank_sel),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .gr_col   (gr_col),
    .gr_rdata (gr_rdata),
    .b0_img   (b0_img),
    .sys_img  (sys_img)
);

// File: tb/sim_bnk_nibram.sv
`timescale 1ns/1ps
module sim_bnk_nibram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b0, wr_en = 1'b0, gr_wr_en = 1'b0;
    logic [6:0] addr = '0;
    logic [3:0] wdata = '0, gr_col = '0, gr_wdata = '0;
    logic [3:0] rdata, gr_rdata;

    logic       s_bank = 1'b0, s_we = 1'b0;
    logic [6:0] s_addr = '0;
    logic [3:0] s_wd = '0, s_rd, s_grd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] m_b0 [128];
    logic [3:0] m_b1 [128];
    logic [3:0] m_sys [12];

    always #2.5 clk = ~clk;

    bnk_nibram u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .gr_col(gr_col), .gr_wr_en(gr_wr_en),
        .gr_wdata(gr_wdata), .gr_rdata(gr_rdata)
    );

    bnk_nibram #(.HAS_BANK1(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bank_sel(s_bank), .addr(s_addr), .wr_en(s_we),
        .wdata(s_wd), .rdata(s_rd), .gr_col(4'h0), .gr_wr_en(1'b0),
        .gr_wdata(4'h0), .gr_rdata(s_grd)
    );

    function automatic logic [3:0] m_read(bit b, logic [6:0] a);
        if (a >= 7'h74)     return m_sys[a - 7'h74];
        if (b && a >= 7'h70) return m_b0[a];
        return b ? m_b1[a] : m_b0[a];
    endfunction

    function automatic logic [6:0] m_gaddr(logic [3:0] c);
        return {m_sys[9][2:0], c};
    endfunction

    function automatic string m_tag(bit b, logic [6:0] a);
        if (a >= 7'h74) return "R4";
        if (b && a >= 7'h70) return "R6";
        return b ? "R3" : "R2";
    endfunction

    task automatic m_write(bit b, logic [6:0] a, logic [3:0] d);
        if (a >= 7'h74)          m_sys[a - 7'h74] = d;
        else if (b && a >= 7'h70) begin end // R5: dropped
        else if (b)              m_b1[a] = d;
        else                     m_b0[a] = d;
    endtask

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, check combinational outputs, then commit.
    task automatic step(bit b, logic [6:0] a, bit we, logic [3:0] d,
                        logic [3:0] c, bit gwe, logic [3:0] gd);
        logic [6:0] ga;
        @(negedge clk);
        bank_sel = b; addr = a; wr_en = we; wdata = d;
        gr_col = c; gr_wr_en = gwe; gr_wdata = gd;
        #1;
        // R11 combinational read
        check(m_tag(b, a), rdata, m_read(b, a));
        ga = m_gaddr(c);
        check("R7", gr_rdata, m_read(b, ga));
        @(posedge clk);
        if (gwe) m_write(b, ga, gd);   // R8
        if (we)  m_write(b, a, d);     // R9: main port last
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 128; i++) begin m_b0[i] = '0; m_b1[i] = '0; end
        for (int i = 0; i < 12; i++) m_sys[i] = '0;
        m_b0[13] = 4'h3;
        m_b0[14] = 4'h2;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset image in both banks
        for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < 128; a++) begin
                @(negedge clk);
                bank_sel = b[0]; addr = a[6:0]; wr_en = 1'b0; gr_wr_en = 1'b0;
                #1 check("R1", rdata, m_read(b[0], a[6:0]));
            end
        end

        // R11 / R2 write then read back next cycle
        step(1'b0, 7'h3A, 1'b1, 4'hC, 4'h0, 1'b0, 4'h0);
        step(1'b0, 7'h3A, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0);

        // R3 same address, other bank, independent
        step(1'b1, 7'h3A, 1'b1, 4'h5, 4'h0, 1'b0, 4'h0);
        step(1'b0, 7'h3A, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0);
        step(1'b1, 7'h3A, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0);

        // R4 write window from bank 1, read from bank 0
        step(1'b1, 7'h78, 1'b1, 4'h9, 4'h0, 1'b0, 4'h0);
        step(1'b0, 7'h78, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0);

        // R5 / R6 protected area
        step(1'b0, 7'h71, 1'b1, 4'hA, 4'h0, 1'b0, 4'h0);
        step(1'b1, 7'h71, 1'b1, 4'h6, 4'h0, 1'b0, 4'h0);
        step(1'b0, 7'h71, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0);
        @(negedge clk); bank_sel = 1'b0; addr = 7'h71; wr_en = 1'b0; #1;
        check("R5", rdata, 4'hA);

        // R8 working row at row 7 in bank 1: column 1 is protected
        step(1'b0, 7'h7D, 1'b1, 4'h7, 4'h0, 1'b0, 4'h0);
        step(1'b1, 7'h00, 1'b0, 4'h0, 4'h1, 1'b1, 4'h3);
        @(negedge clk); bank_sel = 1'b0; addr = 7'h71; wr_en = 1'b0; gr_wr_en = 1'b0; #1;
        check("R8", rdata, 4'hA);

        // R9 collision on 25h
        step(1'b0, 7'h7D, 1'b1, 4'h2, 4'h0, 1'b0, 4'h0);
        step(1'b0, 7'h25, 1'b1, 4'hE, 4'h5, 1'b1, 4'h1);
        @(negedge clk); bank_sel = 1'b0; addr = 7'h25; wr_en = 1'b0; gr_wr_en = 1'b0; #1;
        check("R9", rdata, 4'hE);

        // R10 variant without bank 1
        @(negedge clk); s_bank = 1'b1; s_addr = 7'h10; s_we = 1'b1; s_wd = 4'h9;
        @(negedge clk); s_we = 1'b0; s_bank = 1'b0; #1;
        check("R10", s_rd, 4'h9);
        @(negedge clk); s_bank = 1'b1; s_addr = 7'h72; s_we = 1'b1; s_wd = 4'h4;
        @(negedge clk); s_we = 1'b0; s_bank = 1'b0; #1;
        check("R10", s_rd, 4'h4);
        check("R10", s_grd, 4'h0);

        // random mix, biased toward the top rows
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] a;
            a = $urandom_range(3) == 0 ? 7'(7'h6C + $urandom_range(19)) : 7'($urandom_range(127));
            if ($urandom_range(9) == 0) a = 7'h7D;
            step(1'($urandom_range(1)), a, 1'($urandom_range(1)), 4'($urandom_range(15)),
                 4'($urandom_range(15)), $urandom_range(3) == 0, 4'($urandom_range(15)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule